// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned W-bit integer by another and returns the quotient and the remainder. A caller presents both operands with a one-cycle `start` while the block is idle. The block then works through the quotient bits one per clock, from the most significant down. Each step shifts a signed partial remainder together with the developing quotient. The step then subtracts or adds the divisor, depending on whether the partial remainder was non-negative or negative before the step. A negative partial remainder is never restored straight away. The following step adds the divisor instead, and one correction at the end makes the remainder non-negative.

The partial remainder is one bit wider than the operands, so its top bit is a true sign. When the operation finishes, `done` pulses for one cycle. The result stays on the outputs until the next operation completes. A zero divisor skips the iterations. The block flags it and returns a fixed, recognisable result.

Top module: `nr_divider`

## Requirements
- R1: While `rst` is held high and after its release, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero until the first accepted start.
- R2: A `start` seen while `busy` is low with a non-zero divisor is accepted on that clock edge, and `busy` reads high from the next cycle.
- R3: For a non-zero divisor, `busy` stays high for exactly W+1 cycles after the accepting edge: W iteration cycles and one correction cycle. `done` reads high in the cycle right after the (W+1)th edge that follows the accepting edge.
- R4: For every non-zero divisor, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor. This includes the edge operands 1 and 2^W-1.
- R5: `done` lasts exactly one cycle unless a new operation is started in that same cycle, and `busy` is low whenever `done` is high.
- R6: A `start` raised while `busy` is high is ignored. The running operation keeps its original operands and its completion time.
- R7: A zero divisor accepted while idle raises `done` and `div_by_zero` in the next cycle, without `busy` ever rising. `quotient` is then all ones and `remainder` equals the dividend.
- R8: `quotient` and `remainder` do not change while `busy` is high or while the block is idle. They change only in a cycle where `done` rises.
- R9: `div_by_zero` stays high after a zero-divisor result and returns to zero when the next operation with a non-zero divisor completes.
- R10: When the dividend is smaller than the divisor, the last step leaves the partial remainder negative. The correction adds the divisor back, giving quotient zero and a remainder equal to the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; taken only while `busy` is low |
| dividend | input | W | Unsigned dividend, sampled on the accepting edge |
| divisor | input | W | Unsigned divisor, sampled on the accepting edge |
| quotient | output | W | Quotient of the last completed operation |
| remainder | output | W | Remainder of the last completed operation |
| busy | output | 1 | High while an operation is iterating or correcting |
| done | output | 1 | One-cycle pulse when a result has just been written |
| div_by_zero | output | 1 | The last completed operation had a zero divisor |

## Verification
The assertions assume that `start` is high for only one cycle per intended operation whenever the block is idle. A start held high across `done` would open a new operation in that cycle, and the one-cycle rule for `done` is written with that exception. They also assume that the operands are stable on the accepting edge, because the checker captures them there to verify the result and the latency. The bench drives every input on the falling edge and lowers `start` right after the accepting edge. Its one deliberate overlap is a start raised mid-operation, which the block must ignore.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } nrdiv_state_e;

    // one-hot-ish control strobes from the sequencer to the datapath
    typedef struct packed {
        logic load;      // capture operands, clear partial remainder
        logic iterate;   // apply one shift/add-or-subtract step
        logic finish;    // correct the remainder and publish the result
        logic zero_div;  // publish the fixed zero-divisor result
    } nrdiv_ctl_s;

    // quotient bit produced from the sign of the new partial remainder
    function automatic logic qbit_from_sign(input logic sign);
        return ~sign;
    endfunction

endpackage

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
    parameter int W = 16
) (
    input  logic [W:0]   acc,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] dvs,
    output logic [W:0]   acc_next,
    output logic [W-1:0] quo_next
);
    import nrdiv_pkg::*;

    localparam logic [W:0] ONE = (W+1)'(1);

    logic [W:0]   acc_sh;
    logic [W:0]   dvs_ext;
    logic [W:0]   dvs_neg;
    logic [W-1:0] quo_sh;

    always_comb begin
        acc_sh  = {acc[W-1:0], quo[W-1]};
        quo_sh  = quo << 1;
        dvs_ext = {1'b0, dvs};
        dvs_neg = ~dvs_ext + ONE;
        // sign before the shift chooses add or subtract
        if (acc[W]) begin
            acc_next = acc_sh + dvs_ext;
        end else begin
            acc_next = acc_sh + dvs_neg;
        end
        quo_next = quo_sh | {{(W-1){1'b0}}, qbit_from_sign(acc_next[W])};
    end

endmodule

// File: rtl/nrdiv_fix.sv
module nrdiv_fix #(
    parameter int W = 16
) (
    input  logic [W:0]   acc,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem
);
    logic [W:0] acc_fixed;

    always_comb begin
        if (acc[W]) begin
            acc_fixed = acc + {1'b0, dvs};
        end else begin
            acc_fixed = acc;
        end
        rem = acc_fixed[W-1:0];
    end

endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl #(
    parameter int W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  div_zero,
    output nrdiv_pkg::nrdiv_ctl_s ctl,
    output logic                  busy,
    output logic                  done
);
    import nrdiv_pkg::*;

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(W);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    nrdiv_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        ctl      = '0;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (div_zero) begin
                        ctl.zero_div = 1'b1;
                    end else begin
                        ctl.load = 1'b1;
                        state_d  = ST_ITER;
                    end
                end
            end
            ST_ITER: begin
                ctl.iterate = 1'b1;
                if (cnt_q == CNT_LAST) state_d = ST_FIX;
            end
            ST_FIX: begin
                ctl.finish = 1'b1;
                state_d    = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= ctl.finish | ctl.zero_div;
            if (ctl.load) begin
                cnt_q <= CNT_INIT;
            end else if (ctl.iterate) begin
                cnt_q <= cnt_q - CNT_LAST;
            end
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/nr_divider.sv
module nr_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         busy,
    output logic         done,
    output logic         div_by_zero
);
    import nrdiv_pkg::*;

    nrdiv_ctl_s   ctl;
    logic [W:0]   acc_q, acc_n;
    logic [W-1:0] quo_q, quo_n;
    logic [W-1:0] dvs_q;
    logic [W-1:0] rem_fix;
    logic [W-1:0] res_q, res_r;
    logic         dbz_q;
    logic         divisor_zero;

    assign divisor_zero = (divisor == '0);

    nrdiv_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .div_zero (divisor_zero),
        .ctl      (ctl),
        .busy     (busy),
        .done     (done)
    );

    nrdiv_step #(.W(W)) u_step (
        .acc      (acc_q),
        .quo      (quo_q),
        .dvs      (dvs_q),
        .acc_next (acc_n),
        .quo_next (quo_n)
    );

    nrdiv_fix #(.W(W)) u_fix (
        .acc (acc_q),
        .dvs (dvs_q),
        .rem (rem_fix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            res_q <= '0;
            res_r <= '0;
            dbz_q <= 1'b0;
        end else begin
            if (ctl.load) begin
                acc_q <= '0;
                quo_q <= dividend;
                dvs_q <= divisor;
            end
            if (ctl.iterate) begin
                acc_q <= acc_n;
                quo_q <= quo_n;
            end
            if (ctl.finish) begin
                res_q <= quo_q;
                res_r <= rem_fix;
                dbz_q <= 1'b0;
            end
            if (ctl.zero_div) begin
                res_q <= '1;
                res_r <= dividend;
                dbz_q <= 1'b1;
            end
        end
    end

    assign quotient    = res_q;
    assign remainder   = res_r;
    assign div_by_zero = dbz_q;

endmodule

// File: rtl/nrdiv_checker.sv
module nrdiv_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         busy,
    input logic         done,
    input logic         div_by_zero
);
    logic [W-1:0]   op_a, op_b;
    logic [31:0]    cyc;
    logic [2*W-1:0] qx, bx, rx, ax, recon;
    logic           accept;

    assign accept = start && !busy;
    assign qx     = {{W{1'b0}}, quotient};
    assign bx     = {{W{1'b0}}, op_b};
    assign rx     = {{W{1'b0}}, remainder};
    assign ax     = {{W{1'b0}}, op_a};
    assign recon  = qx * bx + rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_a <= '0;
            op_b <= '0;
            cyc  <= '0;
        end else if (accept) begin
            op_a <= dividend;
            op_b <= divisor;
            cyc  <= '0;
        end else if (busy) begin
            cyc  <= cyc + 32'd1;
        end
    end

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && divisor != '0) |=> busy);

    assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> (cyc == 32'(W + 1)));

    assert_busy_window_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cyc <= 32'(W)));

    assert_result_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> (recon == ax && remainder < op_b));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    assert_ignore_start_R6: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> (busy || done));

    assert_zero_div_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && divisor == '0) |=> (done && div_by_zero && !busy));

    assert_zero_div_value_R7: assert property (@(posedge clk) disable iff (rst)
        (done && div_by_zero) |-> (quotient == '1 && remainder == op_a && op_b == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy || !done) |-> ($stable(quotient) && $stable(remainder)));

endmodule

bind nr_divider nrdiv_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .quotient    (quotient),
    .remainder   (remainder),
    .busy        (busy),
    .done        (done),
    .div_by_zero (div_by_zero)
);

// File: tb/sim_nr_divider.sv
`timescale 1ns/1ps
module sim_nr_divider;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // 4-bit instance
    logic        s4 = 1'b0;
    logic [3:0]  a4 = '0, b4 = '0, q4, r4;
    logic        bs4, d4, z4;
    // 16-bit instance
    logic        s16 = 1'b0;
    logic [15:0] a16 = '0, b16 = '0, q16, r16;
    logic        bs16, d16, z16;

    int n_chk  = 0;
    int n_fail = 0;

    nr_divider #(.W(4)) u0 (
        .clk(clk), .rst(rst), .start(s4), .dividend(a4), .divisor(b4),
        .quotient(q4), .remainder(r4), .busy(bs4), .done(d4), .div_by_zero(z4)
    );

    nr_divider #(.W(16)) u1 (
        .clk(clk), .rst(rst), .start(s16), .dividend(a16), .divisor(b16),
        .quotient(q16), .remainder(r16), .busy(bs16), .done(d16), .div_by_zero(z16)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic sel_done(input bit wide);
        return wide ? d16 : d4;
    endfunction

    // one operation: start, count edges until done, compare result
    task automatic do_op(input bit wide, input logic [15:0] a, input logic [15:0] b,
                         input string req);
        logic [15:0] eq, er, aq, ar;
        int lat, w, exp_lat;
        logic adz;
        w = wide ? 16 : 4;
        if (b == 16'd0) begin
            eq = wide ? 16'hFFFF : 16'h000F;
            er = a;
            exp_lat = 1;
        end else begin
            eq = a / b;
            er = a % b;
            exp_lat = w + 2;
        end
        if (wide) begin s16 = 1'b1; a16 = a; b16 = b; end
        else      begin s4 = 1'b1;  a4 = a[3:0]; b4 = b[3:0]; end
        @(posedge clk);
        @(negedge clk);
        s4 = 1'b0; s16 = 1'b0;
        if (b != 16'd0)
            chk(wide ? bs16 : bs4, "R2", "busy after accept", 0, 1);
        else
            chk(!(wide ? bs16 : bs4), "R7", "busy on zero divisor", 1, 0);
        lat = 1;
        while (!sel_done(wide) && lat < 40) begin
            tick();
            lat++;
        end
        aq  = wide ? q16 : {12'd0, q4};
        ar  = wide ? r16 : {12'd0, r4};
        adz = wide ? z16 : z4;
        chk(lat == exp_lat, b == 16'd0 ? "R7" : "R3", "latency", lat, exp_lat);
        chk(aq == eq, req, "quotient", aq, eq);
        chk(ar == er, req, "remainder", ar, er);
        chk(adz == (b == 16'd0), b == 16'd0 ? "R7" : "R9", "div_by_zero", adz, b == 16'd0);
        chk(!(wide ? bs16 : bs4), "R5", "busy with done", 1, 0);
        tick();
        chk(!sel_done(wide), "R5", "done single cycle", 1, 0);
    endtask

    task automatic test_reset();
        chk(!bs4 && !d4 && !z4, "R1", "u0 flags after reset", {bs4, d4, z4}, 0);
        chk(q4 == 0 && r4 == 0, "R1", "u0 outputs after reset", {q4, r4}, 0);
        chk(!bs16 && !d16 && !z16, "R1", "u1 flags after reset", {bs16, d16, z16}, 0);
        chk(q16 == 0 && r16 == 0, "R1", "u1 outputs after reset", {q16, r16}, 0);
    endtask

    task automatic test_example();
        do_op(1'b0, 16'd11, 16'd3, "R4");
    endtask

    task automatic test_sweep4();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                do_op(1'b0, 16'(a), 16'(b), b == 0 ? "R7" : "R4");
    endtask

    task automatic test_edges16();
        do_op(1'b1, 16'hFFFF, 16'd1, "R4");
        do_op(1'b1, 16'hFFFF, 16'hFFFF, "R4");
        do_op(1'b1, 16'd0, 16'd7, "R4");
        do_op(1'b1, 16'h8000, 16'h7FFF, "R4");
        do_op(1'b1, 16'd1234, 16'd60000, "R10");
        do_op(1'b1, 16'd1, 16'hFFFF, "R10");
        do_op(1'b0, 16'd2, 16'd3, "R10");
    endtask

    task automatic test_random16();
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a, b;
            a = 16'($urandom);
            b = 16'($urandom) >> ($urandom % 16);
            do_op(1'b1, a, b, b == 0 ? "R7" : "R4");
        end
    endtask

    task automatic test_ignore_start();
        int lat;
        s16 = 1'b1; a16 = 16'd1000; b16 = 16'd7;
        tick();
        s16 = 1'b0;
        lat = 1;
        while (!d16 && lat < 40) begin
            if (lat == 4) begin s16 = 1'b1; a16 = 16'd5; b16 = 16'd1; end
            tick();
            lat++;
            s16 = 1'b0;
            if (lat == 5) chk(bs16, "R6", "busy after ignored start", bs16, 1);
        end
        chk(lat == 18, "R6", "latency unchanged", lat, 18);
        chk(q16 == 16'd142, "R6", "quotient of first operands", q16, 142);
        chk(r16 == 16'd6, "R6", "remainder of first operands", r16, 6);
        tick();
    endtask

    task automatic test_hold();
        logic [15:0] hq, hr;
        do_op(1'b1, 16'd50000, 16'd123, "R4");
        hq = q16; hr = r16;
        repeat (5) tick();
        chk(q16 == hq && r16 == hr, "R8", "hold while idle", q16, hq);
        s16 = 1'b1; a16 = 16'd9; b16 = 16'd2;
        tick();
        s16 = 1'b0;
        repeat (6) tick();
        chk(bs16, "R8", "still busy mid-run", bs16, 1);
        chk(q16 == hq, "R8", "quotient held while busy", q16, hq);
        chk(r16 == hr, "R8", "remainder held while busy", r16, hr);
        while (!d16) tick();
        chk(q16 == 16'd4 && r16 == 16'd1, "R8", "new result on done", q16, 4);
        tick();
    endtask

    task automatic test_dbz_clear();
        do_op(1'b1, 16'd77, 16'd0, "R7");
        repeat (3) tick();
        chk(z16, "R9", "flag held after zero divisor", z16, 1);
        do_op(1'b1, 16'd77, 16'd5, "R9");
        chk(!z16, "R9", "flag cleared by normal result", z16, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst = 1'b0;
        tick();
        test_reset();
        test_example();
        test_sweep4();
        test_edges16();
        test_ignore_start();
        test_hold();
        test_dbz_clear();
        test_random16();
        finish_run();
    end

endmodule